// File: doc/BRIEF.md
# USB High-Speed Suspend and Reset Detector

This block sits inside a USB device controller that runs in high-speed mode. It watches the bus line state once a packet has ended and decides whether the host has stopped all traffic to suspend the device or to signal a bus reset. In high-speed mode both conditions start the same way, with the line idle at SE0. The two only differ once the device has switched from high-speed to full-speed termination and the pull-up has had time to act. After that point a suspended bus rises to J, and a bus under reset stays at SE0.

The end-of-packet strobe sets the start point T0. While the line stays at SE0, a microsecond timer runs. At a set time after T0 the block drives both transceiver-select and termination-select high, which puts the PHY into full-speed mode. A fixed interval later it samples the line. J leads to suspend, with the active-low suspend output driven low. SE0 leads to a one-cycle reset indication and a return to high-speed idle. Once the device is suspended, two more flags come on at fixed points after T0: remote wakeup allowed, and the latest point by which the suspend state must be reached. A K state ends suspend as a resume, and SE0 ends it as a reset.

Every threshold is a number of microseconds, and one parameter gives the number of clock cycles in a microsecond. The default values are 60 cycles per microsecond, the switch to full speed at 3000 us, the line sample 110 us later, wakeup allowed at 5000 us, and the deadline at 10000 us.

Top module: `usb_hs_suspend_detect`

## Requirements
- R1: While rst is high and on the first cycle after it, xcvr_select=0, term_select=0, suspend_n=1, wake_en=0, deadline=0 and reset_seen=0.
- R2: A cycle with eop=1 sets T0. If line_state then stays at SE0 (encoding 2'b00), xcvr_select and term_select both go high together on the clock after the elapsed whole microseconds reach T1_US, and not before.
- R3: Before the full-speed switch, any line_state other than SE0 cancels the count. J is 2'b01, K is 2'b10, and 2'b11 is treated like K. After a cancel the outputs stay at their idle values until a later eop.
- R4: eop during the high-speed wait or the full-speed wait restarts timing from zero and drives xcvr_select and term_select low.
- R5: When the elapsed microseconds reach T1_US+SAMPLE_US in full-speed mode and the line is J, suspend_n goes low. xcvr_select and term_select stay high.
- R6: If the line is SE0 at that sample, reset_seen pulses high for exactly one cycle and the block returns to high-speed idle with suspend_n high. If the line is K or 2'b11 at that sample, the block returns to idle without a pulse.
- R7: Between the full-speed switch and the sample point, the line state has no effect.
- R8: wake_en is high exactly while the block is suspended and the elapsed time since T0 is at least WAKE_US.
- R9: deadline is high exactly while the block is suspended and the elapsed time since T0 is at least DEADLINE_US. The elapsed count saturates there, so the flag holds for as long as suspend lasts.
- R10: While suspended, J keeps the state. K or 2'b11 exits to idle with no pulse. SE0 exits to idle with a one-cycle reset_seen. Both exits clear suspend_n low, wake_en and deadline on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 invalid (acts as K) |
| eop | input | 1 | One-cycle end-of-packet strobe that sets T0 |
| xcvr_select | output | 1 | High selects the full-speed transceiver |
| term_select | output | 1 | High selects full-speed termination (pull-up on) |
| suspend_n | output | 1 | Low while the device is suspended |
| wake_en | output | 1 | Remote wakeup is allowed |
| reset_seen | output | 1 | One-cycle pulse when a bus reset is recognised |
| deadline | output | 1 | The latest point for reaching suspend has passed |

## Verification
The bench builds the block with CYC_PER_US=2, T1_US=30, SAMPLE_US=5, WAKE_US=50 and DEADLINE_US=100. The whole suspend timeline, including the deadline, then fits in about 200 cycles, so every path runs many times in one short run. Setting two cycles per microsecond also exercises the prescaler wrap, so an off-by-one error at any threshold shifts an output by a visible cycle. A behavioural model that counts cycles since T0 is compared against every output on every clock.

// File: rtl/usb_sr_pkg.sv
package usb_sr_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    ST_HS_IDLE = 2'd0,
    ST_HS_WAIT = 2'd1,
    ST_FS_WAIT = 2'd2,
    ST_SUSP    = 2'd3
  } det_st_e;

endpackage

// File: rtl/usb_sr_line_decode.sv
module usb_sr_line_decode
  import usb_sr_pkg::*;
(
  input  logic [1:0] line_state,
  output logic       is_se0,
  output logic       is_j,
  output logic       is_kish
);

  always_comb begin
    is_se0  = 1'b0;
    is_j    = 1'b0;
    is_kish = 1'b0;
    case (line_e'(line_state))
      LS_SE0:  is_se0  = 1'b1;
      LS_J:    is_j    = 1'b1;
      default: is_kish = 1'b1;
    endcase
  end

endmodule

// File: rtl/usb_sr_us_timer.sv
module usb_sr_us_timer #(
  parameter int CYC_PER_US = 60,
  parameter int MAX_US     = 10000,
  localparam int UW        = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  output logic [UW-1:0] us_q,
  output logic [UW-1:0] us_d
);

  localparam logic [UW-1:0] MAX_Q = UW'(MAX_US);

  logic tick;

  generate
    if (CYC_PER_US == 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(CYC_PER_US);
      localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
      logic [PW-1:0] pre_q;

      assign tick = (pre_q == PRE_LAST);

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          pre_q <= '0;
        end else if (run) begin
          pre_q <= tick ? '0 : pre_q + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    us_d = us_q;
    if (clr) begin
      us_d = '0;
    end else if (run && tick && (us_q < MAX_Q)) begin
      us_d = us_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) us_q <= '0;
    else     us_q <= us_d;
  end

  assert_timer_saturates_R9: assert property (@(posedge clk) disable iff (rst)
    us_q <= MAX_Q);

  assert_timer_no_backstep_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && run) |=> (us_q >= $past(us_q)));

endmodule

// File: rtl/usb_sr_fsm.sv
module usb_sr_fsm
  import usb_sr_pkg::*;
#(
  parameter int T1_US       = 3000,
  parameter int SAMPLE_US   = 110,
  parameter int WAKE_US     = 5000,
  parameter int DEADLINE_US = 10000,
  parameter int UW          = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_se0,
  input  logic          is_j,
  input  logic          is_kish,
  input  logic          eop,
  input  logic [UW-1:0] us_q,
  input  logic [UW-1:0] us_d,
  output logic          tmr_clr,
  output logic          tmr_run,
  output logic          xcvr_select,
  output logic          term_select,
  output logic          suspend_n,
  output logic          wake_en,
  output logic          reset_seen,
  output logic          deadline
);

  localparam logic [UW-1:0] T1_Q   = UW'(T1_US);
  localparam logic [UW-1:0] SAMP_Q = UW'(T1_US + SAMPLE_US);
  localparam logic [UW-1:0] WAKE_Q = UW'(WAKE_US);
  localparam logic [UW-1:0] DL_Q   = UW'(DEADLINE_US);

  det_st_e st_q, st_d;
  logic    pulse_d;

  assign tmr_run = (st_q != ST_HS_IDLE);
  assign tmr_clr = eop && (st_q != ST_SUSP);

  always_comb begin
    st_d    = st_q;
    pulse_d = 1'b0;
    case (st_q)
      ST_HS_IDLE: if (eop) st_d = ST_HS_WAIT;
      ST_HS_WAIT: begin
        if (eop)              st_d = ST_HS_WAIT;
        else if (!is_se0)     st_d = ST_HS_IDLE;
        else if (us_q >= T1_Q) st_d = ST_FS_WAIT;
      end
      ST_FS_WAIT: begin
        if (eop) begin
          st_d = ST_HS_WAIT;
        end else if (us_q >= SAMP_Q) begin
          if (is_j) begin
            st_d = ST_SUSP;
          end else begin
            st_d    = ST_HS_IDLE;
            pulse_d = is_se0;
          end
        end
      end
      default: begin
        if (is_kish) begin
          st_d = ST_HS_IDLE;
        end else if (is_se0) begin
          st_d    = ST_HS_IDLE;
          pulse_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_HS_IDLE;
      xcvr_select <= 1'b0;
      term_select <= 1'b0;
      suspend_n   <= 1'b1;
      wake_en     <= 1'b0;
      deadline    <= 1'b0;
      reset_seen  <= 1'b0;
    end else begin
      st_q        <= st_d;
      xcvr_select <= (st_d == ST_FS_WAIT) || (st_d == ST_SUSP);
      term_select <= (st_d == ST_FS_WAIT) || (st_d == ST_SUSP);
      suspend_n   <= (st_d != ST_SUSP);
      wake_en     <= (st_d == ST_SUSP) && (us_d >= WAKE_Q);
      deadline    <= (st_d == ST_SUSP) && (us_d >= DL_Q);
      reset_seen  <= pulse_d;
    end
  end

  assert_fs_entry_on_se0_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(xcvr_select) |-> ($past(is_se0) && ($past(us_q) >= T1_Q)));

  assert_cancel_to_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HS_WAIT && !eop && !is_se0) |=> (!xcvr_select && suspend_n));

  assert_susp_in_fs_R5: assert property (@(posedge clk) disable iff (rst)
    !suspend_n |-> (xcvr_select && term_select));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    reset_seen |=> !reset_seen);

  assert_pulse_back_to_hs_R6: assert property (@(posedge clk) disable iff (rst)
    reset_seen |-> (!xcvr_select && !term_select && suspend_n));

  assert_wake_only_suspended_R8: assert property (@(posedge clk) disable iff (rst)
    wake_en |-> !suspend_n);

  assert_deadline_after_wake_R9: assert property (@(posedge clk) disable iff (rst)
    deadline |-> wake_en);

  assert_resume_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SUSP && is_kish) |=> (suspend_n && !wake_en && !deadline && !reset_seen));

endmodule

// File: rtl/usb_hs_suspend_detect.sv
module usb_hs_suspend_detect #(
  parameter int CYC_PER_US  = 60,
  parameter int T1_US       = 3000,
  parameter int SAMPLE_US   = 110,
  parameter int WAKE_US     = 5000,
  parameter int DEADLINE_US = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  input  logic       eop,
  output logic       xcvr_select,
  output logic       term_select,
  output logic       suspend_n,
  output logic       wake_en,
  output logic       reset_seen,
  output logic       deadline
);

  localparam int UW = $clog2(DEADLINE_US + 1);

  logic          is_se0, is_j, is_kish;
  logic          tmr_clr, tmr_run;
  logic [UW-1:0] us_q, us_d;

  usb_sr_line_decode u_dec (
    .line_state (line_state),
    .is_se0     (is_se0),
    .is_j       (is_j),
    .is_kish    (is_kish)
  );

  usb_sr_us_timer #(
    .CYC_PER_US (CYC_PER_US),
    .MAX_US     (DEADLINE_US)
  ) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (tmr_clr),
    .run  (tmr_run),
    .us_q (us_q),
    .us_d (us_d)
  );

  usb_sr_fsm #(
    .T1_US       (T1_US),
    .SAMPLE_US   (SAMPLE_US),
    .WAKE_US     (WAKE_US),
    .DEADLINE_US (DEADLINE_US),
    .UW          (UW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .is_se0      (is_se0),
    .is_j        (is_j),
    .is_kish     (is_kish),
    .eop         (eop),
    .us_q        (us_q),
    .us_d        (us_d),
    .tmr_clr     (tmr_clr),
    .tmr_run     (tmr_run),
    .xcvr_select (xcvr_select),
    .term_select (term_select),
    .suspend_n   (suspend_n),
    .wake_en     (wake_en),
    .reset_seen  (reset_seen),
    .deadline    (deadline)
  );

  assert_selects_paired_R2: assert property (@(posedge clk) disable iff (rst)
    xcvr_select == term_select);

endmodule

// File: tb/usb_hs_suspend_detect_tb.sv
`timescale 1ns/1ps
module usb_hs_suspend_detect_tb;

  localparam int CPU = 2;
  localparam int T1  = 30;
  localparam int SMP = 5;
  localparam int WK  = 50;
  localparam int DL  = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ln  = 2'b01;
  logic       eop = 1'b0;
  logic xcvr_select, term_select, suspend_n, wake_en, reset_seen, deadline;

  int tests = 0;
  int fails = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  usb_hs_suspend_detect #(
    .CYC_PER_US (CPU), .T1_US (T1), .SAMPLE_US (SMP),
    .WAKE_US (WK), .DEADLINE_US (DL)
  ) u_dut (
    .clk (clk), .rst (rst), .line_state (ln), .eop (eop),
    .xcvr_select (xcvr_select), .term_select (term_select),
    .suspend_n (suspend_n), .wake_en (wake_en),
    .reset_seen (reset_seen), .deadline (deadline)
  );

  // behavioural reference: state code 0 idle, 1 HS wait, 2 FS wait, 3 suspended
  int   m_st, m_t, m_us, m_nst;
  logic m_x, m_sn, m_w, m_dl, m_rp;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_t = 0;
      m_x = 0; m_sn = 1; m_w = 0; m_dl = 0; m_rp = 0;
    end else begin
      m_us = m_t / CPU; if (m_us > DL) m_us = DL;
      m_nst = m_st; m_rp = 0;
      case (m_st)
        0: if (eop) m_nst = 1;
        1: if (eop) m_nst = 1; else if (ln != 2'b00) m_nst = 0; else if (m_us >= T1) m_nst = 2;
        2: if (eop) m_nst = 1;
           else if (m_us >= T1 + SMP) begin
             if (ln == 2'b01) m_nst = 3;
             else begin m_nst = 0; m_rp = (ln == 2'b00); end
           end
        default: if (ln == 2'b10 || ln == 2'b11) m_nst = 0;
                 else if (ln == 2'b00) begin m_nst = 0; m_rp = 1; end
      endcase
      if (eop && m_st != 3) m_t = 0;
      else if (m_st != 0) m_t = m_t + 1;
      m_st = m_nst;
      m_us = m_t / CPU; if (m_us > DL) m_us = DL;
      m_x  = (m_st == 2) || (m_st == 3);
      m_sn = (m_st != 3);
      m_w  = (m_st == 3) && (m_us >= WK);
      m_dl = (m_st == 3) && (m_us >= DL);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 xcvr_select model", xcvr_select, m_x);
      chk("R2 term_select model", term_select, m_x);
      chk("R5 suspend_n model", suspend_n, m_sn);
      chk("R8 wake_en model", wake_en, m_w);
      chk("R9 deadline model", deadline, m_dl);
      chk("R6 reset_seen model", reset_seen, m_rp);
      if (reset_seen) pulses++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eop();
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
  endtask

  initial begin
    int p0;
    wait_cyc(4);
    chk("R1 xcvr_select in reset", xcvr_select, 0);
    chk("R1 suspend_n in reset", suspend_n, 1);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1 outputs after reset", {xcvr_select, term_select, wake_en, reset_seen, deadline}, 0);
    chk("R1 suspend_n after reset", suspend_n, 1);

    // full suspend path with noise during FS wait
    ln = 2'b00; pulse_eop();
    wait_cyc(58); chk("R2 no FS before T1", xcvr_select, 0);
    wait_cyc(5);  chk("R2 FS after T1", xcvr_select, 1);
    ln = 2'b10; wait_cyc(2);
    ln = 2'b01; wait_cyc(1); chk("R7 K in FS wait ignored", xcvr_select, 1);
    wait_cyc(10); chk("R5 suspend on J", suspend_n, 0);
    chk("R8 no wake yet", wake_en, 0);
    wait_cyc(40); chk("R8 wake allowed", wake_en, 1);
    chk("R9 no deadline yet", deadline, 0);
    wait_cyc(100); chk("R9 deadline reached", deadline, 1);
    chk("R10 J holds suspend", suspend_n, 0);
    p0 = pulses;
    ln = 2'b10; wait_cyc(2);
    chk("R10 resume clears suspend", {suspend_n, wake_en, deadline, xcvr_select}, 4'b1000);
    chk("R10 resume gives no pulse", pulses - p0, 0);
    ln = 2'b01; wait_cyc(3);

    // cancel before T1
    ln = 2'b00; pulse_eop(); wait_cyc(20);
    ln = 2'b01; wait_cyc(60); chk("R3 J cancels count", xcvr_select, 0);
    ln = 2'b00; wait_cyc(60); chk("R3 no count without eop", xcvr_select, 0);
    ln = 2'b11; wait_cyc(2);
    ln = 2'b00; pulse_eop(); wait_cyc(10);
    ln = 2'b11; wait_cyc(60); chk("R3 invalid state cancels", xcvr_select, 0);

    // eop restarts
    ln = 2'b00; pulse_eop(); wait_cyc(50);
    pulse_eop(); wait_cyc(50); chk("R4 eop restarts HS wait", xcvr_select, 0);
    wait_cyc(15); chk("R4 FS after restart", xcvr_select, 1);
    pulse_eop(); chk("R4 eop in FS wait returns to HS", xcvr_select, 0);
    ln = 2'b01; wait_cyc(3);

    // reset at sample
    p0 = pulses;
    ln = 2'b00; pulse_eop(); wait_cyc(75);
    chk("R6 one reset pulse", pulses - p0, 1);
    chk("R6 back to HS", {xcvr_select, suspend_n}, 2'b01);
    ln = 2'b01; wait_cyc(3);

    // K at sample
    p0 = pulses;
    ln = 2'b00; pulse_eop(); wait_cyc(65);
    ln = 2'b10; wait_cyc(10);
    chk("R6 K at sample no pulse", pulses - p0, 0);
    chk("R6 K at sample idle", {xcvr_select, suspend_n}, 2'b01);
    ln = 2'b01; wait_cyc(3);

    // reset out of suspend
    ln = 2'b00; pulse_eop(); wait_cyc(65);
    ln = 2'b01; wait_cyc(20); chk("R10 suspended before SE0", suspend_n, 0);
    p0 = pulses;
    ln = 2'b00; wait_cyc(2);
    chk("R10 SE0 exit pulse", pulses - p0, 1);
    chk("R10 SE0 exit clears suspend", {suspend_n, xcvr_select}, 2'b10);
    ln = 2'b01; wait_cyc(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule